// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block keeps one private, write-back, direct-mapped cache coherent with its peers on a shared snooping bus. Each line carries a coherence state (invalid, shared or modified). Local processor requests that hit are served at once. A request that misses, or a write to a line that is not held modified, becomes one bus transaction. The possible transactions are a read miss, an invalidate, or a write-back of a modified victim. Every transaction moves a whole block of `WORDS` words.

At the same time the controller watches the transactions that the other caches on the bus are granted. An invalidate for a line it holds drops that line to invalid. A read miss for a line it holds modified makes it step in: it drives the block on the snoop reply, the bus takes that reply in place of the memory response, and its own line falls to shared. The fabric writes the same block into memory in that cycle, so memory is current from the moment the block is shared.

The fabric grants one transaction per cycle, and a granted transaction completes in that cycle. The processor holds its request until `cpu_done`.

Top module: `snoop_wi_ctrl`

## Requirements
- R1: Line states are encoded in 2 bits: invalid 2'b00, shared 2'b01, modified 2'b10. After reset every line is invalid, so the first access to any block issues a bus read miss (bus_cmd 2'b01).
- R2: A read that hits a shared or modified line completes in the cycle it is presented and raises no bus request.
- R3: A write to a line that is not modified issues an invalidate (bus_cmd 2'b10) before it completes. A write miss first issues a read miss and then the invalidate, and the write completes in the cycle after the invalidate is granted.
- R4: A snooped invalidate for a held line makes it invalid, so the next local read of that block goes on the bus as a read miss.
- R5: A snooped read miss for a modified line raises snp_supply with the whole block on snp_data. The line becomes shared, so it supplies no second time, and a later local write to it needs a new invalidate.
- R6: A snooped read miss for a line held shared or not held leaves snp_supply low.
- R7: Before a refill replaces a modified line, the controller writes the victim block back (bus_cmd 2'b11, with the block on bus_wdata). The read miss for the new block follows in the next cycle.
- R8: In a cycle in which snp_valid is high, no local request completes.
- R9: Across two caches sharing memory, every read returns the value of the latest completed write to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Word address |
| cpu_wdata | input | WW | Write data |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_rdata | output | WW | Read data, valid with cpu_done |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Transaction granted and completes this cycle |
| bus_cmd | output | 2 | 00 none, 01 read miss, 10 invalidate, 11 write-back |
| bus_addr | output | AW-log2(WORDS) | Block address of the transaction |
| bus_wdata | output | WORDS*WW | Block being written back |
| bus_rdata | input | WORDS*WW | Refill block (peer reply or memory) |
| snp_valid | input | 1 | Another cache's transaction is granted |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | AW-log2(WORDS) | Block address of the snooped transaction |
| snp_supply | output | 1 | This cache supplies the block and cancels memory |
| snp_data | output | WORDS*WW | Block supplied on intervention |

## Verification
The hardest case to reach is a cache holding a line modified and being asked for it by a peer read miss. A related case is a local hit arriving in the very cycle that a peer's transaction is being snooped. Directed sequences on two controllers force each case: one cache takes a line to modified, the other reads it, and the first cache then writes again. A local read is also started one cycle after the peer's request, so that it lands on the snoop cycle. Seeded random traffic from both sides over a small address space then mixes evictions, upgrades aborted by a peer's invalidate, and interventions. Every read is compared with a bench model of the last written value.

// File: rtl/snoop_wi_ctrl.sv
module snoop_wi_ctrl #(
  parameter int AW     = 6,
  parameter int WW     = 8,
  parameter int WORDS  = 2,
  parameter int NLINES = 4,
  localparam int OB    = $clog2(WORDS),
  localparam int BAW   = AW - OB,
  localparam int BW    = WORDS * WW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [WW-1:0]  cpu_wdata,
  output logic           cpu_done,
  output logic [WW-1:0]  cpu_rdata,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic [1:0]     bus_cmd,
  output logic [BAW-1:0] bus_addr,
  output logic [BW-1:0]  bus_wdata,
  input  logic [BW-1:0]  bus_rdata,
  input  logic           snp_valid,
  input  logic [1:0]     snp_cmd,
  input  logic [BAW-1:0] snp_addr,
  output logic           snp_supply,
  output logic [BW-1:0]  snp_data
);
  localparam int IB = $clog2(NLINES);
  localparam int TW = BAW - IB;

  localparam logic [1:0] L_I = 2'b00, L_S = 2'b01, L_M = 2'b10;
  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_INV = 2'b10, C_WB = 2'b11;

  typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_UPG} fsm_t;
  fsm_t fsm;

  logic [1:0]    lst  [NLINES];
  logic [TW-1:0] ltag [NLINES];
  logic [BW-1:0] ldat [NLINES];

  wire [IB-1:0] idx  = cpu_addr[OB +: IB];
  wire [TW-1:0] tg   = cpu_addr[AW-1 -: TW];
  wire [OB-1:0] off  = cpu_addr[OB-1:0];
  wire          hit  = (lst[idx] != L_I) && (ltag[idx] == tg);
  wire          own  = hit && (lst[idx] == L_M);

  wire [IB-1:0] sidx = snp_addr[IB-1:0];
  wire [TW-1:0] stg  = snp_addr[BAW-1 -: TW];
  wire          shit = snp_valid && (lst[sidx] != L_I) && (ltag[sidx] == stg);

  assign snp_supply = shit && (snp_cmd == C_RD) && (lst[sidx] == L_M);
  assign snp_data   = ldat[sidx];

  assign cpu_done  = (fsm == F_IDLE) && cpu_req && !snp_valid && hit && (!cpu_we || own);
  assign cpu_rdata = ldat[idx][off*WW +: WW];

  assign bus_req = ((fsm == F_WB) && (lst[idx] == L_M)) ||
                   (fsm == F_FILL) ||
                   ((fsm == F_UPG) && hit && (lst[idx] == L_S));
  assign bus_cmd = !bus_req ? C_NONE :
                   (fsm == F_WB)   ? C_WB :
                   (fsm == F_FILL) ? C_RD : C_INV;
  assign bus_addr  = (fsm == F_WB) ? {ltag[idx], idx} : cpu_addr[AW-1:OB];
  assign bus_wdata = ldat[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      for (int i = 0; i < NLINES; i++) lst[i] <= L_I;
    end else begin
      if (shit && snp_cmd == C_INV) lst[sidx] <= L_I;
      else if (snp_supply)          lst[sidx] <= L_S;

      case (fsm)
        F_IDLE: if (cpu_req && !snp_valid) begin
          if (cpu_done) begin
            if (cpu_we) ldat[idx][off*WW +: WW] <= cpu_wdata;
          end else if (hit)              fsm <= F_UPG;
          else if (lst[idx] == L_M)      fsm <= F_WB;
          else                           fsm <= F_FILL;
        end
        F_WB: begin
          if (!bus_req) fsm <= F_FILL;
          else if (bus_gnt) begin
            lst[idx] <= L_I;
            fsm      <= F_FILL;
          end
        end
        F_FILL: if (bus_gnt) begin
          ldat[idx] <= bus_rdata;
          ltag[idx] <= tg;
          lst[idx]  <= L_S;
          fsm       <= F_IDLE;
        end
        F_UPG: begin
          if (!bus_req) fsm <= F_IDLE;
          else if (bus_gnt) begin
            lst[idx] <= L_M;
            fsm      <= F_IDLE;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snoop_wi_chk.sv
module snoop_wi_chk #(
  parameter int BAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_done,
  input logic           bus_req,
  input logic           bus_gnt,
  input logic [1:0]     bus_cmd,
  input logic           snp_valid,
  input logic [1:0]     snp_cmd,
  input logic [BAW-1:0] snp_addr,
  input logic           snp_supply
);
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req);

  p_upgrade_completes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd == 2'b10) |=> (cpu_done || snp_valid));

  p_supply_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && snp_cmd == 2'b01));

  p_supply_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_supply) && snp_valid && snp_cmd == 2'b01 && snp_addr == $past(snp_addr))
      |-> !snp_supply);

  p_wb_then_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_cmd == 2'b11) |=> (bus_req && bus_cmd == 2'b01));

  p_snoop_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_done);

  p_idle_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> (bus_cmd == 2'b00));
endmodule

bind snoop_wi_ctrl snoop_wi_chk #(.BAW(AW - $clog2(WORDS))) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
  .snp_supply(snp_supply)
);

// File: tb/snoop_wi_ctrl_tb.sv
module snoop_wi_ctrl_tb;
  localparam int AW = 6, WW = 8, WORDS = 2, NLINES = 4;
  localparam int BAW = AW - 1, BW = WORDS * WW;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          c_req [2], c_we [2];
  logic [AW-1:0] c_addr [2];
  logic [WW-1:0] c_wd [2], c_rd [2];
  logic          c_done [2];
  logic          req [2], gnt [2], sup [2];
  logic [1:0]    cmd [2];
  logic [BAW-1:0] baddr [2];
  logic [BW-1:0] wdat [2], rdat [2], sdat [2];
  logic [BW-1:0] mem [1<<BAW];
  logic [WW-1:0] golden [1<<AW];

  int nrd [2], ninv [2], nwb [2], supn;
  logic [7:0]    hist [2];
  logic [BW-1:0] wbd [2];
  int tests = 0, fails = 0;

  assign gnt[0]  = req[0];
  assign gnt[1]  = req[1] && !req[0];
  assign rdat[0] = sup[1] ? sdat[1] : mem[baddr[0]];
  assign rdat[1] = sup[0] ? sdat[0] : mem[baddr[1]];

  snoop_wi_ctrl #(.AW(AW), .WW(WW), .WORDS(WORDS), .NLINES(NLINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
    .cpu_wdata(c_wd[0]), .cpu_done(c_done[0]), .cpu_rdata(c_rd[0]),
    .bus_req(req[0]), .bus_gnt(gnt[0]), .bus_cmd(cmd[0]), .bus_addr(baddr[0]),
    .bus_wdata(wdat[0]), .bus_rdata(rdat[0]),
    .snp_valid(gnt[1]), .snp_cmd(cmd[1]), .snp_addr(baddr[1]),
    .snp_supply(sup[0]), .snp_data(sdat[0]));

  snoop_wi_ctrl #(.AW(AW), .WW(WW), .WORDS(WORDS), .NLINES(NLINES)) u_peer (
    .clk(clk), .rst_n(rst_n), .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
    .cpu_wdata(c_wd[1]), .cpu_done(c_done[1]), .cpu_rdata(c_rd[1]),
    .bus_req(req[1]), .bus_gnt(gnt[1]), .bus_cmd(cmd[1]), .bus_addr(baddr[1]),
    .bus_wdata(wdat[1]), .bus_rdata(rdat[1]),
    .snp_valid(gnt[0]), .snp_cmd(cmd[0]), .snp_addr(baddr[0]),
    .snp_supply(sup[1]), .snp_data(sdat[1]));

  always @(posedge clk) begin
    for (int p = 0; p < 2; p++) begin
      if (gnt[p]) begin
        hist[p] <= {hist[p][5:0], cmd[p]};
        if (cmd[p] == 2'b01) nrd[p] <= nrd[p] + 1;
        if (cmd[p] == 2'b10) ninv[p] <= ninv[p] + 1;
        if (cmd[p] == 2'b11) begin
          nwb[p] <= nwb[p] + 1;
          wbd[p] <= wdat[p];
          mem[baddr[p]] <= wdat[p];
        end
        if (cmd[p] == 2'b01 && sup[1-p]) begin
          supn <= supn + 1;
          mem[baddr[p]] <= sdat[1-p];
        end
      end
    end
  end

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic acc(int p, bit we, logic [AW-1:0] a, logic [WW-1:0] d, output int waits);
    @(negedge clk);
    c_req[p] = 1; c_we[p] = we; c_addr[p] = a; c_wd[p] = d; waits = 0;
    forever begin
      #8;
      if (c_done[p]) break;
      waits++;
      @(negedge clk);
    end
    if (we) golden[a] = d;
    else chk("R9 read value", int'(c_rd[p]), int'(golden[a]));
    @(posedge clk); #1;
    c_req[p] = 0;
  endtask

  task automatic rnd_port(int p, int n);
    int w;
    for (int k = 0; k < n; k++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      acc(p, $urandom_range(0, 1) == 1, AW'($urandom_range(0, (1<<AW)-1)),
          WW'($urandom), w);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int w, r0, i0, b0, s0, a9;
    void'($urandom(32'h5eed));
    for (int p = 0; p < 2; p++) begin
      c_req[p] = 0; c_we[p] = 0; c_addr[p] = '0; c_wd[p] = '0;
      nrd[p] = 0; ninv[p] = 0; nwb[p] = 0; hist[p] = '0; wbd[p] = '0;
    end
    supn = 0;
    for (int b = 0; b < (1<<BAW); b++)
      mem[b] <= {WW'((2*b+1) ^ 8'h5A), WW'((2*b) ^ 8'h5A)};
    for (int a = 0; a < (1<<AW); a++) golden[a] = WW'(a ^ 8'h5A);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset done0", int'(c_done[0]), 0);
    chk("R1 reset req0", int'(req[0]), 0);
    chk("R1 reset req1", int'(req[1]), 0);

    r0 = nrd[0];
    acc(0, 0, 6'd0, 8'h00, w);
    chk("R1 first read misses", nrd[0] - r0, 1);

    r0 = nrd[0];
    acc(0, 0, 6'd1, 8'h00, w);
    chk("R2 hit no bus", nrd[0] - r0, 0);
    chk("R2 hit same cycle", w, 0);

    s0 = supn;
    acc(1, 0, 6'd0, 8'h00, w);
    chk("R6 shared no supply", supn - s0, 0);

    r0 = nrd[0]; i0 = ninv[0];
    acc(0, 1, 6'd0, 8'hA1, w);
    chk("R3 invalidate on shared write", ninv[0] - i0, 1);
    chk("R3 no refill on shared write", nrd[0] - r0, 0);

    r0 = nrd[1]; s0 = supn;
    acc(1, 0, 6'd0, 8'h00, w);
    chk("R4 invalidated line misses", nrd[1] - r0, 1);
    chk("R5 owner intervenes", supn - s0, 1);

    i0 = ninv[0];
    acc(0, 1, 6'd0, 8'hA2, w);
    chk("R5 owner became shared", ninv[0] - i0, 1);

    b0 = nwb[0];
    acc(0, 1, 6'd8, 8'hB3, w);
    chk("R7 victim written back", nwb[0] - b0, 1);
    chk("R7 writeback data", int'(wbd[0][7:0]), 8'hA2);
    chk("R3 write miss order wb-rd-inv", int'(hist[0][5:0]), 6'b110110);

    s0 = supn;
    acc(1, 0, 6'd0, 8'h00, w);
    chk("R7 memory holds written back value", supn - s0, 0);

    acc(0, 0, 6'd2, 8'h00, w);
    s0 = supn;
    fork
      acc(1, 1, 6'd8, 8'hC4, w);
      begin
        @(negedge clk);
        acc(0, 0, 6'd2, 8'h00, a9);
      end
    join
    chk("R8 hit stalled by snoop", a9, 1);
    chk("R5 supply before peer write", supn - s0, 1);
    acc(0, 0, 6'd8, 8'h00, w);

    fork
      rnd_port(0, 400);
      rnd_port(1, 400);
    join

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule